// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block receives asynchronous serial characters from a single line and presents them to software through a small register window. The line is sampled once per tick of an external strobe running at sixteen times the bit rate. A start bit counts only after a falling edge whose low level is still present at the middle of the bit. Eight or nine data bits follow, least significant bit first, and then one stop bit. A finished character is placed in a holding register. A level interrupt stays asserted until software reads that register.

A nine-bit mode keeps the extra bit in a status field and does not interpret it. Software may use it as a parity bit or as an address/data marker. In multiprocessor systems an address filter can be turned on. With the filter on, a nine-bit character is kept only when its extra bit is 1, so a node wakes only for address characters. The receiver reports two errors. A framing error means the stop bit sampled low, and the flag belongs to the character in the holding register. An overrun means a character finished while the previous one was still unread. The overrun flag is sticky, blocks any further loads, and clears only when software turns the receiver off.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset the control register (address 0) reads 0, status bits full, overrun and framing (address 1, bits 3, 1, 0) read 0, and irq_o is 0.
- R2: Control bits 0 (port enable), 1 (receive enable), 2 (nine-bit mode) and 3 (address filter) can be written and read back; bits 7..4 read 0. Writes to the status address change nothing.
- R3: While port enable or receive enable is 0, frames on the line load nothing and the framer stays idle.
- R4: In eight-bit mode a frame sent LSB first is loaded into the data register (address 2). Status full (bit 3) and irq_o are set, and the ninth-bit status (bit 2) reads 0.
- R5: In nine-bit mode the ninth received bit appears in status bit 2 and the lower eight bits appear in the data register.
- R6: With nine-bit mode and the address filter both on, a frame whose ninth bit is 0 is discarded, and a frame whose ninth bit is 1 is loaded.
- R7: With the address filter off, every complete frame is loaded whatever its ninth bit.
- R8: The framing flag (status bit 0) is set when a loaded frame's stop bit samples 0. It is replaced by the next frame that loads after the data register has been read.
- R9: A frame that finishes while full is set sets overrun (status bit 1) and leaves the held character unchanged. While overrun is set, no frame loads, even after a read.
- R10: Overrun clears only on a control write with receive enable 0. A control write that keeps receive enable at 1 leaves it set.
- R11: A read of the data register clears full and irq_o.
- R12: A low pulse shorter than half a bit is rejected and loads nothing, and the receiver then still accepts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample strobe at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Register read strobe (side effect on the data address) |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | Receive interrupt, high while a character is held |

## Verification
A framer that loses bit or tick alignment shows up as a wrong data byte or a wrong ninth bit, one read after the stop bit. A stray start state shows up as a load after a glitch or a missing load on the next good frame. An error in the filter or the load gate shows up at once in the full status bit and irq_o, about half a bit before the stop bit ends. An overrun flag that clears itself is caught by the very next status read, and a frame that should have been blocked appears as full set after a read that ought to have left the register empty.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] ADR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADR_DATA = 2'd2;

  localparam int unsigned CB_PORT_EN = 0;
  localparam int unsigned CB_RX_EN   = 1;
  localparam int unsigned CB_NINE    = 2;
  localparam int unsigned CB_ADDR_F  = 3;
  localparam int unsigned CTRL_W     = 4;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_e;

  typedef struct packed {
    logic addr_f;
    logic nine;
    logic rx_en;
    logic port_en;
  } ctrl_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b1;
        else         q <= d_i;
      assign q_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], d_i};
      assign q_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              stop_ok_o,
  output logic              idle_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  fr_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W:0]   sh_q;
  logic              prev_q, nine_q, done_q, stop_q;
  logic [IDX_W-1:0]  last_idx;

  assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      nine_q  <= 1'b0;
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) prev_q <= rx_i;
      if (!en_i) begin
        state_q <= FR_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          FR_IDLE: if (prev_q && !rx_i) begin
            state_q <= FR_START;
            cnt_q   <= '0;
          end
          FR_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              idx_q <= '0;
              nine_q <= nine_i;
              state_q <= rx_i ? FR_IDLE : FR_DATA;  // high at mid-bit: noise
            end
          end
          FR_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[DATA_W:1]};
              if (idx_q == last_idx) state_q <= FR_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
          FR_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              cnt_q   <= '0;
              done_q  <= 1'b1;
              stop_q  <= rx_i;
              state_q <= FR_IDLE;
            end
          end
          default: state_q <= FR_IDLE;
        endcase
      end
    end
  end

  // 8-bit frames end one shift short, so the byte sits in the upper bits
  assign data_o    = nine_q ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
  assign bit9_o    = nine_q & sh_q[DATA_W];
  assign done_o    = done_q;
  assign stop_ok_o = stop_q;
  assign idle_o    = (state_q == FR_IDLE);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  input  logic              stop_ok_i,
  output ctrl_t             ctrl_o,
  output logic [7:0]        rdata_o,
  output logic              full_o,
  output logic              oerr_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              data_rd_o,
  output logic              ctrl_wr_o
);
  ctrl_t             ctrl_q;
  logic              full_q, oerr_q, ferr_q, b9_q;
  logic [DATA_W-1:0] hold_q;
  logic              drop, ctrl_wr, data_rd;

  assign ctrl_wr = wr_i && (addr_i == ADR_CTRL);
  assign data_rd = rd_i && (addr_i == ADR_DATA);
  assign drop    = ctrl_q.nine && ctrl_q.addr_f && !bit9_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      full_q <= 1'b0;
      oerr_q <= 1'b0;
      ferr_q <= 1'b0;
      b9_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (data_rd) full_q <= 1'b0;
      if (done_i && !drop) begin
        if (full_q)       oerr_q <= 1'b1;
        else if (!oerr_q) begin
          hold_q <= data_i;
          b9_q   <= bit9_i;
          ferr_q <= !stop_ok_i;
          full_q <= 1'b1;
        end
      end
      if (ctrl_wr && !wdata_i[CB_RX_EN]) oerr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL: rdata_o = {{(8-CTRL_W){1'b0}}, ctrl_q};
      ADR_STAT: rdata_o = {4'b0, full_q, b9_q, oerr_q, ferr_q};
      ADR_DATA: rdata_o = 8'(hold_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign full_o    = full_q;
  assign oerr_o    = oerr_q;
  assign hold_o    = hold_q;
  assign data_rd_o = data_rd;
  assign ctrl_wr_o = ctrl_wr;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  ctrl_t             ctrl;
  logic              rx_s, frame_done, fr_bit9, fr_stop_ok, fsm_idle;
  logic [DATA_W-1:0] fr_data, hold_data;
  logic              full_q, oerr_q, data_rd, ctrl_wr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk_i, .rst_ni,
    .en_i      (ctrl.port_en && ctrl.rx_en),
    .nine_i    (ctrl.nine),
    .tick_i,
    .rx_i      (rx_s),
    .done_o    (frame_done),
    .data_o    (fr_data),
    .bit9_o    (fr_bit9),
    .stop_ok_o (fr_stop_ok),
    .idle_o    (fsm_idle)
  );

  uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rd_i,
    .done_i    (frame_done),
    .data_i    (fr_data),
    .bit9_i    (fr_bit9),
    .stop_ok_i (fr_stop_ok),
    .ctrl_o    (ctrl),
    .rdata_o,
    .full_o    (full_q),
    .oerr_o    (oerr_q),
    .hold_o    (hold_data),
    .data_rd_o (data_rd),
    .ctrl_wr_o (ctrl_wr)
  );

  assign irq_o = full_q;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              port_en,
  input logic              nine,
  input logic              fsm_idle,
  input logic              frame_done,
  input logic              full_q,
  input logic              oerr_q,
  input logic [DATA_W-1:0] hold_data,
  input logic              data_rd,
  input logic              ctrl_wr,
  input logic [7:0]        wdata_i
);
  // R11
  rd_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !frame_done) |=> !irq_o);

  // R3
  port_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en |=> fsm_idle);

  // R9
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && full_q && !nine && !(ctrl_wr && !wdata_i[1])) |=> oerr_q);

  // R9
  overrun_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_q |=> $stable(hold_data));

  // R10
  overrun_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oerr_q) |-> $past(ctrl_wr && !wdata_i[1]));
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .irq_o,
  .port_en    (ctrl.port_en),
  .nine       (ctrl.nine),
  .fsm_idle   (fsm_idle),
  .frame_done (frame_done),
  .full_q     (full_q),
  .oerr_q     (oerr_q),
  .hold_data  (hold_data),
  .data_rd    (data_rd),
  .ctrl_wr    (ctrl_wr),
  .wdata_i    (wdata_i)
);

// File: tb/sim_uart_addr_rx.sv
`timescale 1ns/1ps
module sim_uart_addr_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  localparam int BIT_CLKS = 64;  // 16 ticks, one tick every 4 clocks

  always #5 clk = ~clk;

  uart_addr_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .irq_o(irq)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick = (tc % 4 == 0);
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic line(input logic b, input int clks);
    @(negedge clk); rx = b;
    repeat (clks - 1) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v, input int nb, input logic stop_ok);
    line(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) line(v[i], BIT_CLKS);
    line(stop_ok, BIT_CLKS);
    line(1'b1, BIT_CLKS);
  endtask

  function automatic bit accepts(input bit nine, input bit filt, input bit b9);
    return !(nine && filt && !b9);
  endfunction

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    peek(2'd0, d); check("R1 ctrl", d, 8'h00);
    peek(2'd1, d); check("R1 status", d & 8'h0B, 8'h00);
    check("R1 irq", irq, 0);

    // R2 control readback, status read-only
    reg_wr(2'd0, 8'hFF); peek(2'd0, d); check("R2 ctrl", d, 8'h0F);
    reg_wr(2'd1, 8'hFF); peek(2'd1, d); check("R2 status ro", d & 8'h0B, 8'h00);

    // R3 disabled receiver ignores the line
    reg_wr(2'd0, 8'h01); send(9'h05A, 8, 1'b1);
    peek(2'd1, d); check("R3 rx_en off", d[3], 0);
    reg_wr(2'd0, 8'h02); send(9'h05A, 8, 1'b1);
    peek(2'd1, d); check("R3 port off", d[3], 0);

    // R4 eight-bit frame, R11 read clears
    reg_wr(2'd0, 8'h03); send(9'h0A5, 8, 1'b1);
    check("R4 irq", irq, 1);
    peek(2'd1, d); check("R4 status", d, 8'h08);
    reg_rd(2'd2, d); check("R4 data", d, 8'hA5);
    check("R11 irq cleared", irq, 0);
    peek(2'd1, d); check("R11 full cleared", d[3], 0);

    // R5 nine-bit data, R7 filter off accepts both ninth-bit values
    reg_wr(2'd0, 8'h07); send(9'h1C3, 9, 1'b1);
    peek(2'd1, d); check("R5 bit9", d[2], 1);
    reg_rd(2'd2, d); check("R5 data", d, 8'hC3);
    send(9'h044, 9, 1'b1);
    peek(2'd1, d); check("R7 full", d[3], 1);
    check("R7 bit9", d[2], 0);
    reg_rd(2'd2, d); check("R7 data", d, 8'h44);

    // R6 address filter
    reg_wr(2'd0, 8'h0F); send(9'h033, 9, 1'b1);
    peek(2'd1, d); check("R6 discard", d[3], 0);
    check("R6 discard irq", irq, 0);
    send(9'h1F0, 9, 1'b1);
    peek(2'd1, d); check("R6 accept", d[3], 1);
    reg_rd(2'd2, d); check("R6 data", d, 8'hF0);

    // R8 framing error set, then replaced by the next good frame
    reg_wr(2'd0, 8'h03); send(9'h081, 8, 1'b0);
    peek(2'd1, d); check("R8 ferr set", d & 8'h0B, 8'h09);
    reg_rd(2'd2, d); check("R8 data", d, 8'h81);
    send(9'h07E, 8, 1'b1);
    peek(2'd1, d); check("R8 ferr cleared", d & 8'h0B, 8'h08);
    reg_rd(2'd2, d); check("R8 data2", d, 8'h7E);

    // R12 short glitch rejected, next frame still works
    line(1'b0, 16); line(1'b1, 3 * BIT_CLKS);
    peek(2'd1, d); check("R12 glitch", d[3], 0);
    send(9'h03C, 8, 1'b1);
    reg_rd(2'd2, d); check("R12 after glitch", d, 8'h3C);

    // R9 overrun
    send(9'h011, 8, 1'b1);
    send(9'h022, 8, 1'b1);
    peek(2'd1, d); check("R9 oerr set", d & 8'h0A, 8'h0A);
    reg_rd(2'd2, d); check("R9 held data", d, 8'h11);
    send(9'h033, 8, 1'b1);
    peek(2'd1, d); check("R9 blocked", d & 8'h0A, 8'h02);
    // R10 clearing rules
    reg_wr(2'd0, 8'h03); peek(2'd1, d); check("R10 kept", d[1], 1);
    reg_wr(2'd0, 8'h01); peek(2'd1, d); check("R10 cleared", d[1], 0);
    reg_wr(2'd0, 8'h03); send(9'h044, 8, 1'b1);
    reg_rd(2'd2, d); check("R10 loads again", d, 8'h44);

    // random frames across modes: R4 R5 R6 R7
    void'($urandom(32'd2024));
    for (int k = 0; k < 24; k++) begin
      bit nine = 1'($urandom % 2);
      bit filt = 1'($urandom % 2);
      logic [8:0] v = 9'($urandom % 512);
      bit acc;
      if (!nine) v[8] = 1'b0;
      acc = accepts(nine, filt, v[8]);
      reg_wr(2'd0, {4'b0, filt, nine, 2'b11});
      send(v, nine ? 9 : 8, 1'b1);
      peek(2'd1, d); check("R6/R7 rand full", d[3], acc);
      if (acc) begin
        check("R5 rand bit9", d[2], v[8]);
        reg_rd(2'd2, d); check("R4 rand data", d, v[7:0]);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule